// File: doc/BRIEF.md
# Flat-Mode Effective Address Generator

This block forms the 64-bit linear address of a memory operand for a 64-bit flat-memory load/store pipeline. In the register form, it adds three terms: an optional base value, an optional index value shifted left by a 2-bit scale code, and a 32-bit signed displacement. In the instruction-pointer-relative form, it adds the displacement to the current instruction pointer instead. Either result can also take a per-thread segment base. Only two selector codes supply such a base. Every other selector code adds zero, because the address space is flat.

A request is presented for one cycle with `req_valid` high. One clock later, the registered address appears together with `addr_valid` and an illegal-mode flag. The absolute-address form and the reserved mode code are not supported. They are reported through the flag and yield a zero address. The output registers keep their contents in any cycle that has no request.

Top module: `flat_ea_gen`

## Requirements
- R1: While `rst_n` is low, and after reset until the first request, `addr_valid`, `addr_illegal` and `addr_out` are all zero.
- R2: `addr_valid` is high in the cycle after a clock edge that sampled `req_valid` high, and low after an edge that sampled it low.
- R3: The 32-bit `disp` is sign-extended from bit 31 before addition. For example, 0x8000_0010 contributes 0xFFFF_FFFF_8000_0010.
- R4: With `req_mode` = 0 (register form), `addr_out` = (`base_en` ? `base_val` : 0) + ((`index_en` ? `index_val` : 0) << scale) + sext(`disp`) + segment base.
- R5: The `scale` code 0, 1, 2, 3 multiplies the index by 1, 2, 4, 8 respectively.
- R6: With `req_mode` = 1 (pointer-relative), `addr_out` = `ip_val` + sext(`disp`) + segment base. `base_en`, `base_val`, `index_en`, `index_val` and `scale` have no effect.
- R7: `req_mode` = 2 (absolute) and `req_mode` = 3 (reserved) set `addr_illegal` and force `addr_out` to zero. Modes 0 and 1 clear `addr_illegal`.
- R8: `seg_sel` = 1 adds `seg0_base`, `seg_sel` = 2 adds `seg1_base`, and `seg_sel` = 0 (none) and 3 (legacy selector) add zero.
- R9: All sums wrap modulo 2^64, with no overflow indication.
- R10: In a cycle without `req_valid`, `addr_out` and `addr_illegal` keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 2 | 0 register form, 1 pointer-relative, 2 absolute (illegal), 3 reserved (illegal) |
| base_en | input | 1 | Base term present |
| base_val | input | 64 | Base register value |
| index_en | input | 1 | Index term present |
| index_val | input | 64 | Index register value |
| scale | input | 2 | Index shift amount, 0..3 |
| disp | input | 32 | Signed displacement |
| ip_val | input | 64 | Instruction pointer for pointer-relative form |
| seg_sel | input | 2 | 0 none, 1 thread segment 0, 2 thread segment 1, 3 legacy selector |
| seg0_base | input | 64 | Base of thread segment 0 |
| seg1_base | input | 64 | Base of thread segment 1 |
| addr_valid | output | 1 | Result valid, one cycle after request |
| addr_out | output | 64 | Linear address |
| addr_illegal | output | 1 | Requested mode is unsupported |

## Verification
The bench sweeps every combination of mode, segment selector, scale code, base enable and index enable. It repeats the sweep with three operand sets: a negative displacement, a large positive displacement and a small one. This separates a sign-extension fault from a scaling or enable fault. In pointer-relative mode, base and index are loaded with nonzero values, so a leak of either term changes the sum. Distinct segment bases make a swapped or missing selector visible. Separate cases push sums across 2^64 and change every input while no request is pending, to expose a load that is not gated by the strobe.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int EA_ADDR_W  = 64;
    localparam int EA_DISP_W  = 32;
    localparam int EA_SCALE_W = 2;

    typedef enum logic [1:0] {
        EA_MODE_REG   = 2'd0,
        EA_MODE_IPREL = 2'd1,
        EA_MODE_ABS   = 2'd2,
        EA_MODE_RSVD  = 2'd3
    } ea_mode_e;

    typedef enum logic [1:0] {
        EA_SEG_NONE   = 2'd0,
        EA_SEG_THR0   = 2'd1,
        EA_SEG_THR1   = 2'd2,
        EA_SEG_LEGACY = 2'd3
    } ea_seg_e;

    typedef struct packed {
        logic                 valid;
        logic                 illegal;
        logic [EA_ADDR_W-1:0] addr;
    } ea_result_t;

endpackage

// File: rtl/ea_disp_extend.sv
module ea_disp_extend #(
    parameter int DISP_W = ea_pkg::EA_DISP_W,
    parameter int ADDR_W = ea_pkg::EA_ADDR_W
) (
    input  logic [DISP_W-1:0] disp_i,
    output logic [ADDR_W-1:0] disp_ext_o
);
    localparam int FILL_W = ADDR_W - DISP_W;

    generate
        if (FILL_W > 0) begin : g_extend
            assign disp_ext_o = {{FILL_W{disp_i[DISP_W-1]}}, disp_i};
        end else begin : g_trunc
            assign disp_ext_o = disp_i[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        if (!$isunknown(disp_i)) begin
            AST_DISP_UPPER_COPY: assert (disp_ext_o[ADDR_W-1] == disp_i[DISP_W-1]); // R3
        end
    end
endmodule

// File: rtl/ea_index_scaler.sv
module ea_index_scaler #(
    parameter int ADDR_W  = ea_pkg::EA_ADDR_W,
    parameter int SCALE_W = ea_pkg::EA_SCALE_W
) (
    input  logic               index_en_i,
    input  logic [ADDR_W-1:0]  index_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic [ADDR_W-1:0]  scaled_o
);
    localparam int N_SCALE = 1 << SCALE_W;

    logic [ADDR_W-1:0] gated;
    logic [ADDR_W-1:0] shifted [N_SCALE];

    assign gated = index_en_i ? index_i : '0;

    genvar k;
    generate
        for (k = 0; k < N_SCALE; k++) begin : g_shift
            assign shifted[k] = gated << k;
        end
    endgenerate

    assign scaled_o = shifted[scale_i];

    always_comb begin
        if (!$isunknown({index_en_i, index_i, scale_i})) begin
            AST_SCALE_LOW_ZERO: assert ((scaled_o & ((ADDR_W'(1) << scale_i) - ADDR_W'(1))) == '0); // R5
            AST_INDEX_OFF_ZERO: assert (index_en_i || scaled_o == '0); // R4
        end
    end
endmodule

// File: rtl/ea_seg_base_mux.sv
module ea_seg_base_mux #(
    parameter int ADDR_W = ea_pkg::EA_ADDR_W
) (
    input  logic [1:0]        seg_sel_i,
    input  logic [ADDR_W-1:0] seg0_base_i,
    input  logic [ADDR_W-1:0] seg1_base_i,
    output logic [ADDR_W-1:0] seg_base_o
);
    import ea_pkg::*;

    always_comb begin
        unique case (ea_seg_e'(seg_sel_i))
            EA_SEG_THR0: seg_base_o = seg0_base_i;
            EA_SEG_THR1: seg_base_o = seg1_base_i;
            default:     seg_base_o = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown(seg_sel_i)) begin
            AST_FLAT_SEG_ZERO: assert (seg_sel_i == 2'd1 || seg_sel_i == 2'd2 || seg_base_o == '0); // R8
        end
    end
endmodule

// File: rtl/flat_ea_gen.sv
module flat_ea_gen #(
    parameter int ADDR_W  = ea_pkg::EA_ADDR_W,
    parameter int DISP_W  = ea_pkg::EA_DISP_W,
    parameter int SCALE_W = ea_pkg::EA_SCALE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_mode,
    input  logic               base_en,
    input  logic [ADDR_W-1:0]  base_val,
    input  logic               index_en,
    input  logic [ADDR_W-1:0]  index_val,
    input  logic [SCALE_W-1:0] scale,
    input  logic [DISP_W-1:0]  disp,
    input  logic [ADDR_W-1:0]  ip_val,
    input  logic [1:0]         seg_sel,
    input  logic [ADDR_W-1:0]  seg0_base,
    input  logic [ADDR_W-1:0]  seg1_base,
    output logic               addr_valid,
    output logic [ADDR_W-1:0]  addr_out,
    output logic               addr_illegal
);
    import ea_pkg::*;

    typedef struct packed {
        logic              valid;
        logic              illegal;
        logic [ADDR_W-1:0] addr;
    } res_t;

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] index_scaled;
    logic [ADDR_W-1:0] seg_base;
    logic [ADDR_W-1:0] reg_form_sum;
    logic [ADDR_W-1:0] ip_form_sum;

    res_t res_d;
    res_t res_q;

    ea_disp_extend #(.DISP_W(DISP_W), .ADDR_W(ADDR_W)) u_disp (
        .disp_i     (disp),
        .disp_ext_o (disp_ext)
    );

    ea_index_scaler #(.ADDR_W(ADDR_W), .SCALE_W(SCALE_W)) u_scale (
        .index_en_i (index_en),
        .index_i    (index_val),
        .scale_i    (scale),
        .scaled_o   (index_scaled)
    );

    ea_seg_base_mux #(.ADDR_W(ADDR_W)) u_seg (
        .seg_sel_i   (seg_sel),
        .seg0_base_i (seg0_base),
        .seg1_base_i (seg1_base),
        .seg_base_o  (seg_base)
    );

    always_comb begin
        reg_form_sum = (base_en ? base_val : '0) + index_scaled + disp_ext + seg_base;
        ip_form_sum  = ip_val + disp_ext + seg_base;

        res_d       = res_q;
        res_d.valid = req_valid;
        if (req_valid) begin
            unique case (ea_mode_e'(req_mode))
                EA_MODE_REG: begin
                    res_d.illegal = 1'b0;
                    res_d.addr    = reg_form_sum;
                end
                EA_MODE_IPREL: begin
                    res_d.illegal = 1'b0;
                    res_d.addr    = ip_form_sum;
                end
                default: begin
                    res_d.illegal = 1'b1;
                    res_d.addr    = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign addr_valid   = res_q.valid;
    assign addr_out     = res_q.addr;
    assign addr_illegal = res_q.illegal;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> addr_valid); // R2
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !addr_valid); // R2
    AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode[1]) |=> (addr_illegal && addr_out == '0)); // R7
    AST_LEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_mode[1]) |=> !addr_illegal); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(addr_out) && $stable(addr_illegal))); // R10
    AST_IPREL_IGNORES_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'd1) |=> addr_out == $past(ip_val + disp_ext + seg_base)); // R6
endmodule

// File: tb/flat_ea_gen_tb_top.sv
module flat_ea_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_mode = '0;
    logic        base_en = 1'b0;
    logic [63:0] base_val = '0;
    logic        index_en = 1'b0;
    logic [63:0] index_val = '0;
    logic [1:0]  scale = '0;
    logic [31:0] disp = '0;
    logic [63:0] ip_val = '0;
    logic [1:0]  seg_sel = '0;
    logic [63:0] seg0_base = '0;
    logic [63:0] seg1_base = '0;
    logic        addr_valid;
    logic [63:0] addr_out;
    logic        addr_illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    flat_ea_gen dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .base_en(base_en), .base_val(base_val), .index_en(index_en),
        .index_val(index_val), .scale(scale), .disp(disp), .ip_val(ip_val),
        .seg_sel(seg_sel), .seg0_base(seg0_base), .seg1_base(seg1_base),
        .addr_valid(addr_valid), .addr_out(addr_out), .addr_illegal(addr_illegal)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [1:0] m, input logic be,
        input logic [63:0] b, input logic ie, input logic [63:0] x, input logic [1:0] s,
        input logic [31:0] d, input logic [63:0] ip, input logic [1:0] ss,
        input logic [63:0] s0, input logic [63:0] s1);
        logic [63:0] dx;
        logic [63:0] sb;
        logic [63:0] mul;
        dx  = {{32{d[31]}}, d};
        sb  = (ss == 2'd1) ? s0 : (ss == 2'd2) ? s1 : 64'd0;
        mul = 64'd1 << s;
        if (m == 2'd0) return (be ? b : 64'd0) + (ie ? x : 64'd0) * mul + dx + sb;
        if (m == 2'd1) return ip + dx + sb;
        return 64'd0;
    endfunction

    task automatic issue(input string tag);
        logic [63:0] exp;
        @(negedge clk);
        req_valid = 1'b1;
        exp = model(req_mode, base_en, base_val, index_en, index_val, scale, disp,
                    ip_val, seg_sel, seg0_base, seg1_base);
        @(negedge clk);
        check({tag, " valid R2"}, {63'd0, addr_valid}, 64'd1);
        check({tag, " addr"}, addr_out, exp);
        check({tag, " illegal R7"}, {63'd0, addr_illegal}, {63'd0, req_mode[1]});
        req_valid = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] disps [3];
        disps[0] = 32'h8000_0010;
        disps[1] = 32'h7FFF_FFF0;
        disps[2] = 32'h0000_1234;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset valid", {63'd0, addr_valid}, 64'd0);
        check("R1 reset addr", addr_out, 64'd0);
        check("R1 reset illegal", {63'd0, addr_illegal}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-reset valid", {63'd0, addr_valid}, 64'd0);

        seg0_base = 64'h0000_7F00_0000_0000;
        seg1_base = 64'h0000_0A00_0010_0000;
        ip_val    = 64'h0000_0000_4000_1000;
        // R3 R4 R5 R6 R7 R8: sweep of all control combinations
        for (int p = 0; p < 3; p++) begin
            base_val  = 64'h0123_4567_89AB_CDE0 + 64'(p * 64'h1111);
            index_val = 64'h0000_0001_0203_0405 + 64'(p * 64'h77);
            disp      = disps[p];
            for (int m = 0; m < 4; m++)
                for (int ss = 0; ss < 4; ss++)
                    for (int sc = 0; sc < 4; sc++)
                        for (int e = 0; e < 4; e++) begin
                            req_mode = 2'(m);
                            seg_sel  = 2'(ss);
                            scale    = 2'(sc);
                            base_en  = e[0];
                            index_en = e[1];
                            issue("R3/R4/R5/R6/R7/R8 sweep");
                        end
        end

        // R9: wrap past 2^64 in both forms
        req_mode = 2'd0; base_en = 1'b1; index_en = 1'b1; scale = 2'd3; seg_sel = 2'd2;
        base_val = 64'hFFFF_FFFF_FFFF_FFF0; index_val = 64'h2000_0000_0000_0001;
        disp = 32'h0000_0020; seg1_base = 64'hF000_0000_0000_0000;
        issue("R9 wrap reg");
        req_mode = 2'd1; ip_val = 64'h0000_0000_0000_0008; disp = 32'hFFFF_FFF0; seg_sel = 2'd0;
        issue("R9 wrap ip");
        check("R9 wrap ip literal", addr_out, 64'hFFFF_FFFF_FFFF_FFF8);

        // R10: idle cycles must not disturb the held result
        req_mode = 2'd0; base_en = 1'b1; base_val = 64'h1000; index_en = 1'b0; disp = 32'h4;
        seg_sel = 2'd0;
        issue("R10 setup");
        @(negedge clk);
        req_mode = 2'd2; base_val = 64'hDEAD_0000; disp = 32'h8000_0000; seg_sel = 2'd1;
        repeat (3) @(negedge clk);
        check("R10 hold addr", addr_out, 64'h1004);
        check("R10 hold illegal", {63'd0, addr_illegal}, 64'd0);
        check("R2 idle valid low", {63'd0, addr_valid}, 64'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule